// File: doc/BRIEF.md
# Status Register Update Unit

This block keeps a processor's 16-bit status word, whose low byte serves as the condition-code byte. Each accepted strobe carries a 4-bit operation code, a 16-bit operand and a privilege level. The operation either combines the operand into the register with AND, XOR or OR, or loads the operand into the register. An operation can act on the whole word or on the condition-code byte alone. Operations on the whole word need supervisor privilege. When a user-level request asks for one, the register is left alone and a one-cycle violation pulse is raised. Operations on the condition-code byte are open to any privilege level.

Two further operations, the plain halt and the low-power halt, load the whole word from the operand and then place the unit in a stopped state. While it is stopped, the unit ignores every strobe. An external resume input ends the stopped state. During a low-power halt, the three-bit interrupt-priority mask (word bits 10..8) is presented on a dedicated bus output with a valid flag. Bit 13 of the word is the supervisor bit. The reset word is 0x2700.

The whole-word bit count, the condition-code byte width, the position and width of the mask field, the reset value and a per-bit implementation mask are parameters. An unimplemented bit always reads 0.

Top module: `sr_update_unit`

## Requirements
- R1: After reset, `sr_o` is 0x2700, and `stopped_o`, `priv_viol_o` and `mask_bus_valid_o` are 0.
- R2: With `priv_i`=1, codes 1 (AND), 2 (XOR) and 3 (OR) combine all 16 operand bits with the register, and the result replaces the register one cycle after the strobe.
- R3: Codes 5 (AND), 6 (XOR) and 7 (OR) combine `operand_i[7:0]` with `sr_o[7:0]`. `sr_o[15:8]` is kept whatever `operand_i[15:8]` holds.
- R4: Code 4 loads all 16 operand bits. Code 8 takes a 16-bit source but writes only its low 8 bits into the condition-code byte and keeps the upper byte.
- R5: The condition-code operations (codes 5 to 8) take effect whatever the value of `priv_i`.
- R6: Codes 1, 2, 3, 4, 9 and 10 are privileged. Such a strobe with `priv_i`=0 leaves `sr_o` and `stopped_o` unchanged and raises `priv_viol_o` in the next cycle only. Back-to-back offences give back-to-back pulses.
- R7: Code 9 (halt) with `priv_i`=1 loads `operand_i` into the register and sets `stopped_o` in the next cycle. `mask_bus_valid_o` stays 0.
- R8: Code 10 (low-power halt) with `priv_i`=1 loads `operand_i`, sets `stopped_o`, and drives `mask_bus_o` = `sr_o[10:8]` with `mask_bus_valid_o`=1 for as long as the unit is stopped. Otherwise `mask_bus_o` is 0.
- R9: While `stopped_o`=1, strobes are ignored: the register does not change and no violation is raised. `resume_i`=1 clears `stopped_o` and `mask_bus_valid_o` at the next edge.
- R10: Code 0, codes 11 to 15, and any cycle with `op_valid_i`=0 leave all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Strobe: operation present this cycle |
| op_i | input | 4 | Operation code |
| operand_i | input | 16 | Immediate or source operand |
| priv_i | input | 1 | 1 = supervisor request, 0 = user request |
| resume_i | input | 1 | Ends the stopped state |
| sr_o | output | 16 | Current status word |
| priv_viol_o | output | 1 | One-cycle privilege-violation pulse |
| stopped_o | output | 1 | Unit is halted |
| mask_bus_o | output | 3 | Interrupt mask driven during a low-power halt |
| mask_bus_valid_o | output | 1 | `mask_bus_o` is being driven |

## Verification
Two events can land in the same cycle: a resume that ends a halt, and a fresh strobe that would otherwise be accepted. The bench drives both at once on a halted unit. It then checks that the unit leaves the stopped state while the register stays untouched, and that the next strobe without resume is applied. The bench also sends a user-level privileged strobe to a halted unit, to confirm that halting takes precedence over violation reporting.

// File: rtl/sru_pkg.sv
package sru_pkg;

   typedef enum logic [3:0] {
      OP_NOP      = 4'd0,
      OP_SR_AND   = 4'd1,
      OP_SR_XOR   = 4'd2,
      OP_SR_OR    = 4'd3,
      OP_SR_LOAD  = 4'd4,
      OP_CC_AND   = 4'd5,
      OP_CC_XOR   = 4'd6,
      OP_CC_OR    = 4'd7,
      OP_CC_LOAD  = 4'd8,
      OP_HALT     = 4'd9,
      OP_HALT_LP  = 4'd10
   } sru_op_e;

   // whole-word writers need supervisor level
   function automatic logic op_needs_priv(input logic [3:0] op);
      case (op)
         OP_SR_AND, OP_SR_XOR, OP_SR_OR, OP_SR_LOAD,
         OP_HALT, OP_HALT_LP: return 1'b1;
         default:             return 1'b0;
      endcase
   endfunction

   function automatic logic op_is_cc(input logic [3:0] op);
      return (op == OP_CC_AND) || (op == OP_CC_XOR) ||
             (op == OP_CC_OR)  || (op == OP_CC_LOAD);
   endfunction

   function automatic logic op_is_halt(input logic [3:0] op);
      return (op == OP_HALT) || (op == OP_HALT_LP);
   endfunction

   function automatic logic op_writes(input logic [3:0] op);
      return op_needs_priv(op) || op_is_cc(op);
   endfunction

endpackage

// File: rtl/sru_alu.sv
module sru_alu
   import sru_pkg::*;
#(
   parameter int SR_W = 16,
   parameter int CC_W = 8
) (
   input  logic [3:0]      op_i,
   input  logic [SR_W-1:0] operand_i,
   input  logic [SR_W-1:0] cur_i,
   output logic [SR_W-1:0] nxt_o
);

   localparam int HI_W = SR_W - CC_W;

   logic [CC_W-1:0] cc_cur, cc_opd, cc_res;
   logic [HI_W-1:0] hi_cur, hi_opd, hi_res;

   assign cc_cur = cur_i[CC_W-1:0];
   assign cc_opd = operand_i[CC_W-1:0];
   assign hi_cur = cur_i[SR_W-1:CC_W];
   assign hi_opd = operand_i[SR_W-1:CC_W];

   // low lane: touched by both whole-word and byte operations
   always_comb begin
      case (sru_op_e'(op_i))
         OP_SR_AND, OP_CC_AND:             cc_res = cc_cur & cc_opd;
         OP_SR_XOR, OP_CC_XOR:             cc_res = cc_cur ^ cc_opd;
         OP_SR_OR,  OP_CC_OR:              cc_res = cc_cur | cc_opd;
         OP_SR_LOAD, OP_CC_LOAD,
         OP_HALT, OP_HALT_LP:              cc_res = cc_opd;
         default:                          cc_res = cc_cur;
      endcase
   end

   // high lane: only whole-word operations reach it
   always_comb begin
      case (sru_op_e'(op_i))
         OP_SR_AND:                        hi_res = hi_cur & hi_opd;
         OP_SR_XOR:                        hi_res = hi_cur ^ hi_opd;
         OP_SR_OR:                         hi_res = hi_cur | hi_opd;
         OP_SR_LOAD, OP_HALT, OP_HALT_LP:  hi_res = hi_opd;
         default:                          hi_res = hi_cur;
      endcase
   end

   assign nxt_o = {hi_res, cc_res};

endmodule

// File: rtl/sru_ctrl.sv
module sru_ctrl
   import sru_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       op_valid_i,
   input  logic [3:0] op_i,
   input  logic       priv_i,
   input  logic       resume_i,
   output logic       sr_we_o,
   output logic       viol_o,
   output logic       stopped_o,
   output logic       lowpow_o
);

   logic stopped_q, lowpow_q, viol_q;
   logic accept, need_priv, grant;

   assign accept    = op_valid_i && !stopped_q;
   assign need_priv = op_needs_priv(op_i);
   assign grant     = accept && (!need_priv || priv_i);
   assign sr_we_o   = grant && op_writes(op_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_q    <= 1'b0;
         stopped_q <= 1'b0;
         lowpow_q  <= 1'b0;
      end else begin
         viol_q <= accept && need_priv && !priv_i;
         if (stopped_q) begin
            if (resume_i) begin
               stopped_q <= 1'b0;
               lowpow_q  <= 1'b0;
            end
         end else if (grant && op_is_halt(op_i)) begin
            stopped_q <= 1'b1;
            lowpow_q  <= (op_i == OP_HALT_LP);
         end
      end
   end

   assign viol_o    = viol_q;
   assign stopped_o = stopped_q;
   assign lowpow_o  = lowpow_q;

endmodule

// File: rtl/sru_sreg.sv
module sru_sreg #(
   parameter int              SR_W      = 16,
   parameter logic [SR_W-1:0] RESET_VAL = 16'h2700,
   parameter logic [SR_W-1:0] IMPL_MASK = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic [SR_W-1:0] d_i,
   output logic [SR_W-1:0] q_o
);

   for (genvar b = 0; b < SR_W; b++) begin : g_bit
      if (IMPL_MASK[b]) begin : g_flop
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    bit_q <= RESET_VAL[b];
            else if (we_i) bit_q <= d_i[b];
         end
         assign q_o[b] = bit_q;
      end else begin : g_tie
         assign q_o[b] = 1'b0;
      end
   end

endmodule

// File: rtl/sr_update_unit.sv
module sr_update_unit
   import sru_pkg::*;
#(
   parameter int              SR_W      = 16,
   parameter int              CC_W      = 8,
   parameter int              MASK_LSB  = 8,
   parameter int              MASK_W    = 3,
   parameter int              SUP_BIT   = 13,
   parameter logic [SR_W-1:0] RESET_VAL = 16'h2700,
   parameter logic [SR_W-1:0] IMPL_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid_i,
   input  logic [3:0]        op_i,
   input  logic [SR_W-1:0]   operand_i,
   input  logic              priv_i,
   input  logic              resume_i,
   output logic [SR_W-1:0]   sr_o,
   output logic              priv_viol_o,
   output logic              stopped_o,
   output logic [MASK_W-1:0] mask_bus_o,
   output logic              mask_bus_valid_o
);

   if (CC_W < 1 || CC_W >= SR_W) begin : g_bad_cc
      $error("condition-code width must be below the word width");
   end
   if (MASK_LSB + MASK_W > SR_W) begin : g_bad_mask
      $error("mask field lies outside the word");
   end
   if (SUP_BIT >= SR_W || (SUP_BIT >= MASK_LSB && SUP_BIT < MASK_LSB + MASK_W)) begin : g_bad_sup
      $error("supervisor bit misplaced");
   end
   if ((RESET_VAL & ~IMPL_MASK) != '0) begin : g_bad_rst
      $error("reset value sets an unimplemented bit");
   end

   logic [SR_W-1:0] sr_q, sr_nxt;
   logic            sr_we, lowpow;

   sru_alu #(.SR_W(SR_W), .CC_W(CC_W)) u_alu (
      .op_i      (op_i),
      .operand_i (operand_i),
      .cur_i     (sr_q),
      .nxt_o     (sr_nxt)
   );

   sru_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_valid_i (op_valid_i),
      .op_i       (op_i),
      .priv_i     (priv_i),
      .resume_i   (resume_i),
      .sr_we_o    (sr_we),
      .viol_o     (priv_viol_o),
      .stopped_o  (stopped_o),
      .lowpow_o   (lowpow)
   );

   sru_sreg #(.SR_W(SR_W), .RESET_VAL(RESET_VAL), .IMPL_MASK(IMPL_MASK)) u_sreg (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (sr_we),
      .d_i   (sr_nxt),
      .q_o   (sr_q)
   );

   assign sr_o             = sr_q;
   assign mask_bus_valid_o = lowpow;
   assign mask_bus_o       = lowpow ? sr_q[MASK_LSB +: MASK_W] : '0;

endmodule

// File: rtl/sru_checker.sv
module sru_checker
   import sru_pkg::*;
#(
   parameter int              SR_W      = 16,
   parameter int              CC_W      = 8,
   parameter logic [SR_W-1:0] IMPL_MASK = '1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            op_valid_i,
   input logic [3:0]      op_i,
   input logic [SR_W-1:0] operand_i,
   input logic            priv_i,
   input logic            resume_i,
   input logic [SR_W-1:0] sr_o,
   input logic            priv_viol_o,
   input logic            stopped_o,
   input logic            mask_bus_valid_o
);

   AST_CC_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && !stopped_o && op_is_cc(op_i)) |=> sr_o[SR_W-1:CC_W] == $past(sr_o[SR_W-1:CC_W])); // R3

   AST_VIOL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      priv_viol_o |-> $past(op_valid_i && !stopped_o && !priv_i && op_needs_priv(op_i))); // R6

   AST_VIOL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && !stopped_o && !priv_i && op_needs_priv(op_i)) |=> $stable(sr_o)); // R6

   AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && !stopped_o && priv_i && op_is_halt(op_i)) |=>
         (stopped_o && sr_o == ($past(operand_i) & IMPL_MASK))); // R7

   AST_MASK_ONLY_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      mask_bus_valid_o |-> stopped_o); // R8

   AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped_o && !resume_i) |=> (stopped_o && $stable(sr_o) && !priv_viol_o)); // R9

   AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped_o && resume_i) |=> (!stopped_o && !mask_bus_valid_o)); // R9

endmodule

bind sr_update_unit sru_checker #(.SR_W(SR_W), .CC_W(CC_W), .IMPL_MASK(IMPL_MASK)) u_sru_checker (
   .clk              (clk),
   .rst_n            (rst_n),
   .op_valid_i       (op_valid_i),
   .op_i             (op_i),
   .operand_i        (operand_i),
   .priv_i           (priv_i),
   .resume_i         (resume_i),
   .sr_o             (sr_o),
   .priv_viol_o      (priv_viol_o),
   .stopped_o        (stopped_o),
   .mask_bus_valid_o (mask_bus_valid_o)
);

// File: tb/sr_update_unit_bench.sv
module sr_update_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid_i = 1'b0;
   logic [3:0]  op_i = 4'd0;
   logic [15:0] operand_i = 16'd0;
   logic        priv_i = 1'b0;
   logic        resume_i = 1'b0;
   logic [15:0] sr_o;
   logic        priv_viol_o, stopped_o, mask_bus_valid_o;
   logic [2:0]  mask_bus_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   sr_update_unit u_sr_update_unit (
      .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
      .operand_i(operand_i), .priv_i(priv_i), .resume_i(resume_i),
      .sr_o(sr_o), .priv_viol_o(priv_viol_o), .stopped_o(stopped_o),
      .mask_bus_o(mask_bus_o), .mask_bus_valid_o(mask_bus_valid_o)
   );

   typedef struct packed {
      logic [3:0]  op;
      logic [15:0] opd;
      logic        priv;
      logic [15:0] exp_sr;
      logic        exp_viol;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{4'd3,  16'h001F, 1'b1, 16'h271F, 1'b0},
      '{4'd1,  16'hA7F5, 1'b1, 16'h2715, 1'b0},
      '{4'd2,  16'h0303, 1'b1, 16'h2416, 1'b0},
      '{4'd7,  16'hFF08, 1'b0, 16'h241E, 1'b0},
      '{4'd5,  16'h0006, 1'b0, 16'h2406, 1'b0},
      '{4'd6,  16'h5A1F, 1'b1, 16'h2419, 1'b0},
      '{4'd8,  16'hC3A5, 1'b0, 16'h24A5, 1'b0},
      '{4'd4,  16'h0000, 1'b0, 16'h24A5, 1'b1},
      '{4'd3,  16'hFFFF, 1'b0, 16'h24A5, 1'b1},
      '{4'd0,  16'hFFFF, 1'b1, 16'h24A5, 1'b0},
      '{4'd15, 16'h0000, 1'b1, 16'h24A5, 1'b0},
      '{4'd4,  16'h2313, 1'b1, 16'h2313, 1'b0},
      '{4'd2,  16'h2000, 1'b1, 16'h0313, 1'b0},
      '{4'd9,  16'h2000, 1'b0, 16'h0313, 1'b1}
   };

   function automatic string tag_of(input vec_t v);
      if (v.exp_viol)                  return "R6";
      if (v.op >= 4'd1 && v.op <= 4'd3) return "R2";
      if (v.op >= 4'd5 && v.op <= 4'd7) return "R3";
      if (v.op == 4'd4 || v.op == 4'd8) return "R4";
      return "R10";
   endfunction

   task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive at negedge, let one rising edge pass, sample 2 ns later
   task automatic step(input logic v, input logic [3:0] op, input logic [15:0] opd,
                       input logic pr, input logic rs);
      @(negedge clk);
      op_valid_i = v; op_i = op; operand_i = opd; priv_i = pr; resume_i = rs;
      @(posedge clk);
      #2;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "reset sr", sr_o, 16'h2700);
      chk("R1", "reset stopped", {15'd0, stopped_o}, 16'd0);
      chk("R1", "reset viol", {15'd0, priv_viol_o}, 16'd0);
      chk("R1", "reset bus valid", {15'd0, mask_bus_valid_o}, 16'd0);

      for (int i = 0; i < NV; i++) begin
         step(1'b1, VECS[i].op, VECS[i].opd, VECS[i].priv, 1'b0);
         chk(tag_of(VECS[i]), "table sr", sr_o, VECS[i].exp_sr);
         chk(tag_of(VECS[i]), "table viol", {15'd0, priv_viol_o}, {15'd0, VECS[i].exp_viol});
         chk("R6", "table no halt", {15'd0, stopped_o}, 16'd0);
      end

      // R6: pulse lasts one cycle
      step(1'b0, 4'd4, 16'hFFFF, 1'b0, 1'b0);
      chk("R6", "viol drops", {15'd0, priv_viol_o}, 16'd0);
      // R10: no strobe, no change
      chk("R10", "idle sr", sr_o, 16'h0313);
      // R5: byte op allowed at user level
      step(1'b1, 4'd7, 16'h0080, 1'b0, 1'b0);
      chk("R5", "user cc or", sr_o, 16'h0393);

      // R7: plain halt
      step(1'b1, 4'd9, 16'h2104, 1'b1, 1'b0);
      chk("R7", "halt sr", sr_o, 16'h2104);
      chk("R7", "halt stopped", {15'd0, stopped_o}, 16'd1);
      chk("R7", "halt no bus", {15'd0, mask_bus_valid_o}, 16'd0);
      // R9: strobes ignored while stopped
      step(1'b1, 4'd4, 16'h0000, 1'b1, 1'b0);
      chk("R9", "stopped sv load", sr_o, 16'h2104);
      step(1'b1, 4'd4, 16'h0000, 1'b0, 1'b0);
      chk("R9", "stopped no viol", {15'd0, priv_viol_o}, 16'd0);
      chk("R9", "still stopped", {15'd0, stopped_o}, 16'd1);
      // R9: resume and strobe together
      step(1'b1, 4'd7, 16'h00FF, 1'b1, 1'b1);
      chk("R9", "resume clears", {15'd0, stopped_o}, 16'd0);
      chk("R9", "resume strobe ignored", sr_o, 16'h2104);
      step(1'b1, 4'd7, 16'h0001, 1'b0, 1'b0);
      chk("R9", "post resume accept", sr_o, 16'h2105);

      // R8: low-power halt
      step(1'b1, 4'd10, 16'h2500, 1'b1, 1'b0);
      chk("R8", "lp sr", sr_o, 16'h2500);
      chk("R8", "lp stopped", {15'd0, stopped_o}, 16'd1);
      chk("R8", "lp bus valid", {15'd0, mask_bus_valid_o}, 16'd1);
      chk("R8", "lp bus mask", {13'd0, mask_bus_o}, 16'd5);
      repeat (3) step(1'b0, 4'd0, 16'h0000, 1'b0, 1'b0);
      chk("R8", "lp held", {13'd0, mask_bus_o}, 16'd5);
      step(1'b0, 4'd0, 16'h0000, 1'b0, 1'b1);
      chk("R9", "lp resume", {15'd0, stopped_o}, 16'd0);
      chk("R8", "lp bus off", {12'd0, mask_bus_valid_o, mask_bus_o}, 16'd0);

      // R4: byte load keeps upper byte
      step(1'b1, 4'd8, 16'hFF3C, 1'b1, 1'b0);
      chk("R4", "cc load", sr_o, 16'h253C);

      // R1: reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", "async reset sr", sr_o, 16'h2700);
      @(negedge clk);
      rst_n = 1'b1;
      finish_run();
   end

endmodule